// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that completes every instruction in exactly one clock cycle. It runs a fixed nine-instruction subset: four register-to-register arithmetic and logic operations, a signed set-on-less-than, a word load, a word store, a branch on equal and an unconditional jump. A program counter addresses a private instruction memory. A second, separate data memory serves loads and stores, so the fetch and the data access happen in the same cycle. The core also holds a 32-entry register file, an ALU with a zero flag, an offset sign extender and the next-PC selection. A control unit drives the datapath through a small bundle of strobes.

Both memories are small word arrays inside the core. They are filled through one write port that accepts data only while the core is held in synchronous reset. When reset is released, the core executes from address 0. Its architectural effects appear on three trace outputs: the program counter, the register write-back and the data-memory write.

Top module: `scpu_top`

## Requirements
- R1: While `rst` is high, `regWrEn` and `memWrEn` stay low. On the first cycle after `rst` falls, `pcOut` is 0 and every register reads as 0.
- R2: Opcode 0x00 with shamt (bits 10..6) equal to 0 and funct (bits 5..0) equal to 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt into rd. The fields are rs = bits 25..21, rt = bits 20..16 and rd = bits 15..11.
- R3: Opcode 0x00 with funct 0x2A writes 1 into rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Opcode 0x23 reads the data word at rs plus the sign-extended bits 15..0 and writes it into rt. The data memory is indexed by address bits [DAW+1:2], so higher address bits wrap.
- R5: Opcode 0x2B writes rt to the data word selected as in R4. It asserts `memWrEn` with the full byte address and the data, and it writes no register.
- R6: Opcode 0x04 moves the PC to PC+4 plus (the sign-extended bits 15..0 shifted left by 2) when rs equals rt. Otherwise the PC moves to PC+4. No register or memory is written.
- R7: Opcode 0x02 moves the PC to {PC+4 bits 31..28, instruction bits 25..0, 2'b00}.
- R8: Every instruction other than a taken branch or a jump advances the PC by exactly 4. Instructions are fetched from the word at PC bits [IAW+1:2].
- R9: Register 0 always reads as 0. A write aimed at it is dropped, and `regWrEn` stays low for it.
- R10: Any other opcode, or opcode 0x00 with another funct or a nonzero shamt, writes nothing and advances the PC by 4.
- R11: The load port writes instruction memory (`loadToData`=0) or data memory (`loadToData`=1) at word `loadAddr` only while `rst` is high. While running, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| loadEn | input | 1 | Load-port write strobe |
| loadToData | input | 1 | Load target: 0 instruction memory, 1 data memory |
| loadAddr | input | LAW | Word index of the load-port write |
| loadData | input | 32 | Word written through the load port |
| pcOut | output | 32 | Address of the instruction executing this cycle |
| regWrEn | output | 1 | A register is written at the coming edge |
| regWrAddr | output | 5 | Register being written |
| regWrData | output | 32 | Value being written to the register |
| memWrEn | output | 1 | Data memory is written at the coming edge |
| memWrAddr | output | 32 | Byte address of the data write |
| memWrData | output | 32 | Word being stored |

## Verification
Any corruption of the program counter, a register or a data word surfaces at the trace ports within the cycle in which the corrupted value is next used. A wrong PC shows on `pcOut` one cycle after the bad update. A wrong register shows on the write-back or store data of the next instruction that reads it. A wrong data word shows on the write-back of the next load from it. The bench runs a reference instruction-set model in lockstep and compares all trace ports every cycle. Errors that never reach an architectural write therefore show up the first time they are used, and errors that do reach one show up at once.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int RAW = $clog2(REG_COUNT);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    regWrite;
    logic    destIsRd;
    logic    useImm;
    logic    memWrite;
    logic    loadResult;
    logic    branchEq;
    logic    jump;
    alu_fn_e aluFn;
  } strobes_t;
endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output strobes_t   strobes
);
  typedef enum logic [1:0] {CLS_ADD, CLS_SUB, CLS_FUNCT} alu_cls_e;

  alu_cls_e aluCls;
  alu_fn_e  rFn;
  logic     rValid;

  // ALU control decoder: funct field to ALU function
  always_comb begin
    rValid = (shamt == 5'd0);
    rFn    = ALU_ADD;
    case (funct)
      FN_ADD:  rFn = ALU_ADD;
      FN_SUB:  rFn = ALU_SUB;
      FN_AND:  rFn = ALU_AND;
      FN_OR:   rFn = ALU_OR;
      FN_SLT:  rFn = ALU_SLT;
      default: rValid = 1'b0;
    endcase
  end

  // Main decoder: opcode to strobes
  always_comb begin
    strobes = '0;
    aluCls  = CLS_ADD;
    case (opcode)
      OP_RTYPE: begin
        strobes.regWrite = rValid;
        strobes.destIsRd = 1'b1;
        aluCls           = CLS_FUNCT;
      end
      OP_LW: begin
        strobes.regWrite   = 1'b1;
        strobes.useImm     = 1'b1;
        strobes.loadResult = 1'b1;
      end
      OP_SW: begin
        strobes.useImm   = 1'b1;
        strobes.memWrite = 1'b1;
      end
      OP_BEQ: begin
        strobes.branchEq = 1'b1;
        aluCls           = CLS_SUB;
      end
      OP_J:    strobes.jump = 1'b1;
      default: ;
    endcase
    case (aluCls)
      CLS_SUB:   strobes.aluFn = ALU_SUB;
      CLS_FUNCT: strobes.aluFn = rFn;
      default:   strobes.aluFn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rdAddrA,
  input  logic [RAW-1:0]  rdAddrB,
  input  logic            wrEn,
  input  logic [RAW-1:0]  wrAddr,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);
  logic [XLEN-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  always_comb begin
    case (fn)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        strobes,
  input  logic            loadEn,
  input  logic            loadToData,
  input  logic [LAW-1:0]  loadAddr,
  input  logic [XLEN-1:0] loadData,
  output logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] pcOut,
  output logic            regWrEn,
  output logic [RAW-1:0]  regWrAddr,
  output logic [XLEN-1:0] regWrData,
  output logic            memWrEn,
  output logic [XLEN-1:0] memWrAddr,
  output logic [XLEN-1:0] memWrData
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pcNext, pcPlus4, brTarget, jmpTarget, immExt;
  logic [XLEN-1:0] rsVal, rtVal, aluB, aluY, loadWord;
  logic [RAW-1:0]  rsIdx, rtIdx, destIdx;
  logic [DAW-1:0]  dIdx;
  logic            aluZero, takeBranch;

  // Fetch
  assign instr   = imem[pc[IAW+1:2]];
  assign rsIdx   = instr[25:21];
  assign rtIdx   = instr[20:16];
  assign destIdx = strobes.destIsRd ? instr[15:11] : rtIdx;
  assign immExt  = {{(XLEN-16){instr[15]}}, instr[15:0]};

  scpu_regfile u_regfile (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .wrEn    (regWrEn),
    .wrAddr  (destIdx),
    .wrData  (regWrData),
    .rdDataA (rsVal),
    .rdDataB (rtVal)
  );

  assign aluB = strobes.useImm ? immExt : rtVal;

  scpu_alu u_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .fn     (strobes.aluFn),
    .result (aluY),
    .zero   (aluZero)
  );

  // Data memory
  assign dIdx     = aluY[DAW+1:2];
  assign loadWord = dmem[dIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn && loadToData) dmem[loadAddr[DAW-1:0]] <= loadData;
    end else if (strobes.memWrite) begin
      dmem[dIdx] <= rtVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadToData) imem[loadAddr[IAW-1:0]] <= loadData;
  end

  // Next PC
  assign pcPlus4    = pc + XLEN'(4);
  assign brTarget   = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget  = {pcPlus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign takeBranch = strobes.branchEq && aluZero;

  always_comb begin
    if (strobes.jump)    pcNext = jmpTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  // Trace outputs
  assign pcOut     = pc;
  assign regWrEn   = strobes.regWrite && !rst && (destIdx != '0);
  assign regWrAddr = destIdx;
  assign regWrData = strobes.loadResult ? loadWord : aluY;
  assign memWrEn   = strobes.memWrite && !rst;
  assign memWrAddr = aluY;
  assign memWrData = rtVal;
endmodule

// File: rtl/scpu_top.sv
module scpu_top
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic             loadToData,
  input  logic [LAW-1:0]   loadAddr,
  input  logic [31:0]      loadData,
  output logic [31:0]      pcOut,
  output logic             regWrEn,
  output logic [4:0]       regWrAddr,
  output logic [31:0]      regWrData,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [31:0]      memWrData
);
  strobes_t        strobes;
  logic [XLEN-1:0] instrW;

  scpu_control u_control (
    .opcode  (instrW[31:26]),
    .funct   (instrW[5:0]),
    .shamt   (instrW[10:6]),
    .strobes (strobes)
  );

  scpu_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .instr      (instrW),
    .pcOut      (pcOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );
endmodule

// File: rtl/scpu_checker.sv
module scpu_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input logic        regWrEn,
  input logic [4:0]  regWrAddr,
  input logic        memWrEn
);
  logic [5:0]  op;
  logic [31:0] jTarget;
  logic        knownOp;
  logic        rstQ;

  assign op      = instr[31:26];
  assign jTarget = {pcOut[31:28] + {3'b000, (pcOut[27:2] == 26'h3FFFFFF)}, instr[25:0], 2'b00};
  assign knownOp = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04) || (op == 6'h02);

  always_ff @(posedge clk) rstQ <= rst;

  always @(negedge clk) begin
    if (rst) AST_QUIET_IN_RESET: assert (!regWrEn && !memWrEn);     // R1
    if (rstQ && !rst) AST_PC_FROM_ZERO: assert (pcOut == 32'd0);    // R1
  end

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> (regWrAddr != 5'd0));                                // R9
  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> (op == 6'h2B));                                      // R5
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    ((op != 6'h04) && (op != 6'h02)) |=> (pcOut == $past(pcOut) + 32'd4)); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> (pcOut == $past(jTarget)));                    // R7
  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> (!regWrEn && !memWrEn));                            // R10
  AST_LW_DEST: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'h23) && (instr[20:16] != 5'd0)) |-> (regWrEn && regWrAddr == instr[20:16])); // R4
  AST_BEQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04) |-> (!regWrEn && !memWrEn));                       // R6
endmodule

bind scpu_top scpu_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .pcOut     (pcOut),
  .instr     (instrW),
  .regWrEn   (regWrEn),
  .regWrAddr (regWrAddr),
  .memWrEn   (memWrEn)
);

// File: tb/test_scpu_top.sv
`timescale 1ns/1ps
module test_scpu_top;
  localparam int IW  = 64;
  localparam int DW  = 64;
  localparam int IAW = $clog2(IW);
  localparam int DAW = $clog2(DW);
  localparam int LAW = (IAW > DAW) ? IAW : DAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           loadEn = 1'b0;
  logic           loadToData = 1'b0;
  logic [LAW-1:0] loadAddr = '0;
  logic [31:0]    loadData = '0;
  logic [31:0]    pcOut, regWrData, memWrAddr, memWrData;
  logic [4:0]     regWrAddr;
  logic           regWrEn, memWrEn;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;  // 125 MHz

  scpu_top #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_scpu_top (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .pcOut(pcOut),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  // Reference model state
  logic [31:0] mImem [IW];
  logic [31:0] mDmem [DW];
  logic [31:0] mReg  [32];
  logic [31:0] mPc;
  string       pcTag = "R1";
  string       forceTag = "";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    string t;
    t = (forceTag != "") ? forceTag : tag;
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %08h expected %08h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int rd, int rs, int rt, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  // Compare the trace ports against the model, then advance the model
  task automatic compareStep();
    logic [31:0] ins, a, b, se, pc4, nxt, res, addr;
    logic [5:0]  op, fn;
    bit          eReg, eMem;
    int          rd;
    string       tag;
    ins = mImem[mPc[IAW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = mReg[ins[25:21]]; b = mReg[ins[20:16]];
    se = {{16{ins[15]}}, ins[15:0]};
    pc4 = mPc + 32'd4; nxt = pc4;
    eReg = 0; eMem = 0; rd = 0; res = '0; addr = '0; tag = "R10";
    case (op)
      6'h00: if (ins[10:6] == 5'd0) begin
        rd = int'(ins[15:11]); eReg = 1; tag = "R2";
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default: begin eReg = 0; tag = "R10"; end
        endcase
      end
      6'h23: begin
        addr = a + se; rd = int'(ins[20:16]); eReg = 1;
        res = mDmem[addr[DAW+1:2]]; tag = "R4";
      end
      6'h2B: begin addr = a + se; eMem = 1; tag = "R5"; end
      6'h04: begin tag = "R6"; if (a == b) nxt = pc4 + (se << 2); end
      6'h02: begin tag = "R7"; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
      default: tag = "R10";
    endcase
    if (eReg && rd == 0) begin eReg = 0; tag = "R9"; end

    chk(pcTag, "pcOut", pcOut, mPc);
    chk(tag, "regWrEn", {31'd0, regWrEn}, {31'd0, eReg});
    if (eReg) begin
      chk(tag, "regWrAddr", {27'd0, regWrAddr}, 32'(rd));
      chk(tag, "regWrData", regWrData, res);
    end
    chk(tag, "memWrEn", {31'd0, memWrEn}, {31'd0, eMem});
    if (eMem) begin
      chk(tag, "memWrAddr", memWrAddr, addr);
      chk(tag, "memWrData", memWrData, b);
    end

    if (eReg) mReg[rd] = res;
    if (eMem) mDmem[addr[DAW+1:2]] = b;
    pcTag = (tag == "R6" || tag == "R7") ? tag : "R8";
    mPc = nxt;
  endtask

  // Load both memories during reset, then release reset
  task automatic loadAndStart();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < IW + DW; i++) begin
      loadEn = 1'b1;
      loadToData = (i >= IW);
      loadAddr = LAW'((i >= IW) ? i - IW : i);
      loadData = (i >= IW) ? mDmem[i - IW] : mImem[i];
      @(negedge clk);
      #1;
      chk("R1", "regWrEn in reset", {31'd0, regWrEn}, 32'd0);
      chk("R1", "memWrEn in reset", {31'd0, memWrEn}, 32'd0);
    end
    loadEn = 1'b0;
    mPc = '0;
    for (int r = 0; r < 32; r++) mReg[r] = '0;
    pcTag = "R1";
    rst = 1'b0;
  endtask

  task automatic runCycles(int n, bit noisy);
    for (int c = 0; c < n; c++) begin
      if (noisy) begin
        loadEn = 1'b1;
        loadToData = $urandom() % 2 == 1;
        loadAddr = LAW'($urandom());
        loadData = $urandom();
      end
      #1;
      compareStep();
      @(negedge clk);
    end
    loadEn = 1'b0;
  endtask

  function automatic logic [31:0] randInstr();
    int k;
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    k = int'($urandom() % 100);
    if (k < 40) return encR(int'($urandom() % 8), int'($urandom() % 8), int'($urandom() % 8), fns[$urandom() % 5]);
    if (k < 55) return encI(6'h23, int'($urandom() % 8), int'($urandom() % 8), int'($urandom() % 64) - 32);
    if (k < 68) return encI(6'h2B, int'($urandom() % 8), int'($urandom() % 8), int'($urandom() % 64) - 32);
    if (k < 80) return encI(6'h04, int'($urandom() % 4), int'($urandom() % 4), int'($urandom() % 13) - 6);
    if (k < 86) return encJ(int'($urandom() % IW));
    if (k < 92) return {6'(8 + $urandom() % 8), 26'($urandom())};
    if (k < 96) return encR(1, 2, 3, 6'h21);
    return encR(1, 2, 3, 6'h20) | 32'h0000_0040;  // nonzero shamt
  endfunction

  initial begin
    #(8ns * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd9137));

    // Directed program covering every instruction class
    for (int i = 0; i < IW; i++) mImem[i] = 32'hFC00_0000;
    for (int i = 0; i < DW; i++) mDmem[i] = 32'(i * 3);
    mDmem[0] = 32'h8000_0005;
    mDmem[1] = 32'd7;
    mImem[0]  = encI(6'h23, 0, 1, 0);        // lw r1
    mImem[1]  = encI(6'h23, 0, 2, 4);        // lw r2
    mImem[2]  = encR(3, 1, 2, 6'h20);        // R2 add
    mImem[3]  = encR(4, 2, 1, 6'h22);        // R2 sub
    mImem[4]  = encR(5, 1, 2, 6'h24);        // R2 and
    mImem[5]  = encR(6, 1, 2, 6'h25);        // R2 or
    mImem[6]  = encR(7, 1, 2, 6'h2A);        // R3 negative < positive
    mImem[7]  = encR(8, 2, 1, 6'h2A);        // R3 false case
    mImem[8]  = encR(0, 1, 2, 6'h20);        // R9 write to r0
    mImem[9]  = encI(6'h2B, 0, 3, 8);        // R5 store
    mImem[10] = encI(6'h2B, 0, 2, -4);       // R5 wraps to last word
    mImem[11] = 32'hFC00_0000;               // R10 unknown opcode
    mImem[12] = encR(9, 1, 2, 6'h21);        // R10 unknown funct
    mImem[13] = encI(6'h04, 1, 2, 5);        // R6 not taken
    mImem[14] = encI(6'h04, 2, 2, 2);        // R6 taken to 17
    mImem[15] = encR(9, 1, 1, 6'h20);
    mImem[16] = encR(9, 1, 1, 6'h20);
    mImem[17] = encI(6'h23, 0, 10, -4);      // R4 wrapped load
    mImem[18] = encJ(20);                    // R7
    mImem[19] = encR(11, 1, 1, 6'h20);
    mImem[20] = encI(6'h23, 0, 13, 8);       // loop: lw r13
    mImem[21] = encJ(20);
    loadAndStart();
    runCycles(30, 1'b0);
    forceTag = "R11";                        // load port while running
    runCycles(40, 1'b1);
    forceTag = "";

    // Reset mid-run restarts from zero
    loadAndStart();
    runCycles(10, 1'b0);

    // Constrained random programs
    for (int p = 0; p < 20; p++) begin
      for (int i = 0; i < IW; i++) mImem[i] = randInstr();
      for (int i = 0; i < DW; i++) mDmem[i] = $urandom();
      loadAndStart();
      runCycles(300, (p % 2) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule